// File: doc/BRIEF.md
# Interrupt Status Aggregator

This block collects interrupt requests from several GPIO banks and from a set of peripheral sources, and folds them into one pending-status word and a single request line to the host. Each GPIO bank presents its per-pin status together with its own per-pin mask, where a 1 hides the pin. The block reduces each bank to one summary bit. Peripheral requests are level inputs, and each one is gated by an enable bit that software controls.

Software sees two registers behind a small read/write port. The status register is read-only, and the enable register holds the peripheral enables and one global enable. The host input is edge-sensitive. A service routine reads the status word again and again until it reads zero. After each status read the request line drops for one cycle, so a condition that is still pending gives the host a fresh rising edge.

Top module: `irq_status_aggregator`

## Requirements
- R1: Status bit b (0 to NBANK-1) is 1 exactly when bank b has at least one pin whose status is 1 and whose pin-mask bit is 0. A pin-mask bit of 1 hides that pin.
- R2: Status bit NBANK+k is 1 exactly when peripheral input k is 1 and enable-register bit NBANK+k is 1. An enable bit of 1 lets the source through, and 0 blocks it.
- R3: A read with reg_addr=0 returns the status word on reg_rdata in the cycle after reg_rd. With the defaults the status occupies bits 9:0, and bits 15:10 are always 0.
- R4: The enable register is at reg_addr=1. Only bit 0 (global enable) and bits NBANK..NBANK+NPERI-1 store written values. All other bits read as 0. A write to reg_addr=0 changes nothing.
- R5: irq_out is registered. It is 1 in a cycle only if, at the preceding clock edge, the global enable was 1, the status word was nonzero, and no status read was taking place.
- R6: In the cycle after each status read, irq_out is 0. If the status is still nonzero and the global enable is still 1, irq_out returns to 1 one cycle later. Back-to-back reads keep it low throughout.
- R7: After reset the enable register is all zero, and irq_out and reg_rdata are 0.
- R8: A read with reg_addr=1 returns the enable register contents in the cycle after reg_rd. When no read is taking place, reg_rdata is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bank_pin_stat | input | NBANK*PINS | Per-pin interrupt status of all banks, bank b in slice b*PINS |
| bank_pin_mask | input | NBANK*PINS | Per-pin mask of all banks, 1 hides the pin |
| peri_irq | input | NPERI | Level requests of the peripheral sources |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 1 | 0 selects status, 1 selects enable register |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Read data, valid the cycle after reg_rd |
| irq_out | output | 1 | Request line to the host |

## Verification
The bench builds the block with four banks of four pins each, six peripheral sources and a 16-bit register word. The small pin count puts every visible/hidden pin combination of a bank within reach of random stimulus. The full 10-bit status layout and the six reserved upper register bits stay exactly as they are in the default build. Directed sequences cover the global enable gating, the enable-register write filter, and single and back-to-back status reads while sources remain pending.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  // register select on the one-bit address
  typedef enum logic {
    SEL_STATUS = 1'b0,
    SEL_ENABLE = 1'b1
  } reg_sel_e;

  // position of the global enable inside the enable register
  localparam int GEN_BIT = 0;

endpackage

// File: rtl/irq_bank_fold.sv
module irq_bank_fold #(
  parameter int PINS = 16
) (
  input  logic [PINS-1:0] pin_stat,
  input  logic [PINS-1:0] pin_mask,
  output logic            summary
);

  // a pin counts when its status is set and its mask bit is clear
  function automatic logic fold(input logic [PINS-1:0] st, input logic [PINS-1:0] mk);
    logic acc;
    acc = 1'b0;
    for (int i = 0; i < PINS; i++) begin
      acc = acc | (st[i] & ~mk[i]);
    end
    return acc;
  endfunction

  always_comb summary = fold(pin_stat, pin_mask);

endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_agg_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int NPERI = 6,
  parameter int REG_W = 16,
  localparam int NSTAT = NBANK + NPERI
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             rd,
  input  logic             addr,
  input  logic [REG_W-1:0] wdata,
  input  logic [NSTAT-1:0] status,
  output logic [REG_W-1:0] rdata,
  output logic [NPERI-1:0] peri_en,
  output logic             gen_en,
  output logic             rd_status,
  output logic             wr_enable
);

  // bits of the enable register that hold state
  function automatic logic [REG_W-1:0] writable_bits();
    logic [REG_W-1:0] m;
    m = '0;
    m[GEN_BIT] = 1'b1;
    for (int i = NBANK; i < NSTAT; i++) begin
      m[i] = 1'b1;
    end
    return m;
  endfunction

  localparam logic [REG_W-1:0] WMASK = writable_bits();

  logic [REG_W-1:0] en_q;
  logic [REG_W-1:0] status_ext;
  reg_sel_e         sel;

  always_comb begin
    sel        = reg_sel_e'(addr);
    rd_status  = rd && (sel == SEL_STATUS);
    wr_enable  = wr && (sel == SEL_ENABLE);
    status_ext = '0;
    status_ext[NSTAT-1:0] = status;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (wr_enable) begin
      en_q <= wdata & WMASK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd) begin
      rdata <= (sel == SEL_STATUS) ? status_ext : en_q;
    end else begin
      rdata <= '0;
    end
  end

  assign peri_en = en_q[NSTAT-1:NBANK];
  assign gen_en  = en_q[GEN_BIT];

endmodule

// File: rtl/irq_out_shaper.sv
module irq_out_shaper (
  input  logic clk,
  input  logic rst_n,
  input  logic gen_en,
  input  logic pend_any,
  input  logic rd_status,
  output logic irq_out
);

  // a status read forces one low cycle so a still-pending source re-rises
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_out <= 1'b0;
    end else begin
      irq_out <= gen_en && pend_any && !rd_status;
    end
  end

endmodule

// File: rtl/irq_status_aggregator.sv
module irq_status_aggregator #(
  parameter int NBANK = 4,
  parameter int PINS  = 16,
  parameter int NPERI = 6,
  parameter int REG_W = 16,
  localparam int NSTAT = NBANK + NPERI,
  localparam int NPIN  = NBANK * PINS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPIN-1:0]  bank_pin_stat,
  input  logic [NPIN-1:0]  bank_pin_mask,
  input  logic [NPERI-1:0] peri_irq,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic             reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             irq_out
);

  logic [NBANK-1:0] bank_sum;
  logic [NPERI-1:0] peri_en;
  logic [NPERI-1:0] peri_gated;
  logic [NSTAT-1:0] status_vec;
  logic             gen_en;
  logic             pend_any;
  logic             rd_status;
  logic             wr_enable;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    irq_bank_fold #(.PINS(PINS)) u_fold (
      .pin_stat (bank_pin_stat[b*PINS +: PINS]),
      .pin_mask (bank_pin_mask[b*PINS +: PINS]),
      .summary  (bank_sum[b])
    );
  end

  for (genvar k = 0; k < NPERI; k++) begin : g_peri
    assign peri_gated[k] = peri_irq[k] & peri_en[k];
  end

  assign status_vec = {peri_gated, bank_sum};
  assign pend_any   = |status_vec;

  irq_regs #(.NBANK(NBANK), .NPERI(NPERI), .REG_W(REG_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (reg_wr),
    .rd        (reg_rd),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .status    (status_vec),
    .rdata     (reg_rdata),
    .peri_en   (peri_en),
    .gen_en    (gen_en),
    .rd_status (rd_status),
    .wr_enable (wr_enable)
  );

  irq_out_shaper u_shape (
    .clk       (clk),
    .rst_n     (rst_n),
    .gen_en    (gen_en),
    .pend_any  (pend_any),
    .rd_status (rd_status),
    .irq_out   (irq_out)
  );

endmodule

// File: rtl/irq_status_aggregator_chk.sv
module irq_status_aggregator_chk #(
  parameter int NBANK = 4,
  parameter int NPERI = 6,
  parameter int REG_W = 16,
  localparam int NSTAT = NBANK + NPERI
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPERI-1:0] peri_irq,
  input logic [NPERI-1:0] peri_en,
  input logic [NSTAT-1:0] status_vec,
  input logic             gen_en,
  input logic             pend_any,
  input logic             rd_status,
  input logic             wr_enable,
  input logic [REG_W-1:0] reg_rdata,
  input logic             irq_out
);

  // R5: a request on the line needs enable, pending and no read at the prior edge
  p_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> $past(gen_en && pend_any && !rd_status));

  // R5: with the global enable clear, the line falls at the next edge
  p_gen_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_en |=> !irq_out);

  // R6: a status read is followed by one low cycle
  p_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_status |=> !irq_out);

  // R2: a disabled peripheral never shows up in the status word
  p_peri_block_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (status_vec[NSTAT-1:NBANK] & ~(peri_en & peri_irq)) == '0);

  // R3: read data above the status width is always zero
  p_rd_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[REG_W-1:NSTAT] == '0);

  // R4: the enable settings only move on an enable-register write
  p_en_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_enable |=> ($stable(peri_en) && $stable(gen_en)));

endmodule

bind irq_status_aggregator irq_status_aggregator_chk #(
  .NBANK(NBANK), .NPERI(NPERI), .REG_W(REG_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .peri_irq   (peri_irq),
  .peri_en    (peri_en),
  .status_vec (status_vec),
  .gen_en     (gen_en),
  .pend_any   (pend_any),
  .rd_status  (rd_status),
  .wr_enable  (wr_enable),
  .reg_rdata  (reg_rdata),
  .irq_out    (irq_out)
);

// File: tb/irq_status_aggregator_bench.sv
`timescale 1ns/1ps
module irq_status_aggregator_bench;

  localparam int NBANK = 4;
  localparam int PINS  = 4;
  localparam int NPERI = 6;
  localparam int REG_W = 16;
  localparam int NPIN  = NBANK * PINS;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NPIN-1:0]  bank_pin_stat = '0;
  logic [NPIN-1:0]  bank_pin_mask = '0;
  logic [NPERI-1:0] peri_irq = '0;
  logic             reg_wr = 1'b0;
  logic             reg_rd = 1'b0;
  logic             reg_addr = 1'b0;
  logic [REG_W-1:0] reg_wdata = '0;
  logic [REG_W-1:0] reg_rdata;
  logic             irq_out;

  int checks = 0;
  int fails  = 0;
  string cur_req = "R7";

  always #2 clk = ~clk;

  irq_status_aggregator #(
    .NBANK(NBANK), .PINS(PINS), .NPERI(NPERI), .REG_W(REG_W)
  ) u_irq_status_aggregator (
    .clk           (clk),
    .rst_n         (rst_n),
    .bank_pin_stat (bank_pin_stat),
    .bank_pin_mask (bank_pin_mask),
    .peri_irq      (peri_irq),
    .reg_wr        (reg_wr),
    .reg_rd        (reg_rd),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .reg_rdata     (reg_rdata),
    .irq_out       (irq_out)
  );

  // behavioural reference: enable register as an integer, status rebuilt by scanning
  int m_en;
  int exp_rdata;
  bit exp_irq;

  function automatic int model_status();
    int s;
    s = 0;
    for (int b = 0; b < NBANK; b++) begin
      for (int p = 0; p < PINS; p++) begin
        if (bank_pin_stat[b*PINS+p] && !bank_pin_mask[b*PINS+p]) s = s | (1 << b);
      end
    end
    for (int k = 0; k < NPERI; k++) begin
      if (peri_irq[k] && ((m_en >> (NBANK+k)) & 1) != 0) s = s | (1 << (NBANK+k));
    end
    return s;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en <= 0; exp_rdata <= 0; exp_irq <= 1'b0;
    end else begin
      int st;
      st = model_status();
      exp_rdata <= reg_rd ? (reg_addr ? m_en : st) : 0;
      exp_irq   <= ((m_en & 1) != 0) && (st != 0) && !(reg_rd && !reg_addr);
      if (reg_wr && reg_addr) m_en <= int'(reg_wdata) & 32'h03F1;
    end
  end

  task automatic check(input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  // advance to the next falling edge and compare against the reference
  task automatic cyc();
    @(negedge clk);
    check(int'(irq_out), int'(exp_irq), "irq_out vs model");
    check(int'(reg_rdata), exp_rdata, "reg_rdata vs model");
  endtask

  task automatic wr_reg(input bit a, input int d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d[REG_W-1:0];
    cyc();
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input bit a, output int v);
    reg_rd = 1'b1; reg_addr = a;
    cyc();
    reg_rd = 1'b0;
    v = int'(reg_rdata);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int v;
    // R7: reset state
    cur_req = "R7";
    repeat (3) @(negedge clk);
    check(int'(irq_out), 0, "irq_out in reset");
    check(int'(reg_rdata), 0, "rdata in reset");
    rst_n = 1'b1;
    cyc();
    rd_reg(1'b1, v);
    check(v, 0, "enable register after reset");

    // R4 / R8: write filter and readback
    cur_req = "R4";
    wr_reg(1'b1, 32'hFFFF);
    rd_reg(1'b1, v);
    check(v, 32'h03F1, "enable register keeps bits 0 and 4..9");
    wr_reg(1'b0, 32'h0000);
    cur_req = "R8";
    rd_reg(1'b1, v);
    check(v, 32'h03F1, "status-address write left enable register");
    cyc();
    check(int'(reg_rdata), 0, "rdata idle without read");

    // R1: bank folding with pin masks
    cur_req = "R1";
    bank_pin_stat[0*PINS+2] = 1'b1;
    bank_pin_stat[2*PINS+1] = 1'b1; bank_pin_mask[2*PINS+1] = 1'b1;
    cyc();
    rd_reg(1'b0, v);
    check(v, 32'h0001, "bank2 pin hidden by mask");
    bank_pin_mask[2*PINS+1] = 1'b0;
    cyc();
    rd_reg(1'b0, v);
    check(v, 32'h0005, "bank2 pin unmasked");
    bank_pin_mask = '1;
    cyc();
    rd_reg(1'b0, v);
    check(v, 32'h0000, "all pins masked");
    bank_pin_mask = '0; bank_pin_stat = '0;

    // R2: peripheral enables
    cur_req = "R2";
    wr_reg(1'b1, 32'h0091);
    peri_irq = 6'b101001;
    cyc();
    rd_reg(1'b0, v);
    check(v, 32'h0090, "only enabled peripherals 0 and 3");

    // R5: global enable gating
    cur_req = "R5";
    wr_reg(1'b1, 32'h0090);
    cyc(); cyc();
    check(int'(irq_out), 0, "global enable off");
    wr_reg(1'b1, 32'h0091);
    cyc();
    check(int'(irq_out), 1, "global enable on with pending");
    peri_irq = '0;
    cyc();
    check(int'(irq_out), 0, "no pending source");

    // R6: low cycle after status reads
    cur_req = "R6";
    peri_irq = 6'b000001;
    cyc(); cyc();
    check(int'(irq_out), 1, "pending before read");
    rd_reg(1'b0, v);
    check(int'(irq_out), 0, "low cycle after read");
    cyc();
    check(int'(irq_out), 1, "re-rise after read");
    reg_rd = 1'b1; reg_addr = 1'b0;
    cyc();
    check(int'(irq_out), 0, "back-to-back read 1");
    cyc();
    check(int'(irq_out), 0, "back-to-back read 2");
    reg_rd = 1'b0;
    cyc();
    check(int'(irq_out), 1, "re-rise after burst");

    // R3: full status word and zero upper bits
    cur_req = "R3";
    wr_reg(1'b1, 32'h03F1);
    peri_irq = '1;
    for (int b = 0; b < NBANK; b++) bank_pin_stat[b*PINS] = 1'b1;
    cyc();
    rd_reg(1'b0, v);
    check(v, 32'h03FF, "all ten status bits");

    // random traffic against the model
    cur_req = "R5";
    for (int i = 0; i < 600; i++) begin
      bank_pin_stat = NPIN'($urandom);
      bank_pin_mask = NPIN'($urandom | $urandom);
      peri_irq      = NPERI'($urandom);
      reg_rd        = ($urandom % 4) == 0;
      reg_wr        = ($urandom % 8) == 0;
      reg_addr      = 1'($urandom);
      reg_wdata     = REG_W'($urandom);
      cyc();
    end
    reg_rd = 1'b0; reg_wr = 1'b0;
    cyc();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule